// File: doc/BRIEF.md
# Wired-AND Shared Bus Resolver

This block stands in for an on-chip shared bus that several three-state-style drivers can drive. No real tri-state buffers are used; the bus is built from ordinary logic. Each driver has its own data word and its own active-low enable. The block merges all drivers into one resolved bus word under two rules: an idle bus floats high, and a conflict always goes low. Every bit position is resolved on its own.

Next to the resolved word, the block gives registered visibility of the drive state. It reports which drivers were enabled, how many were enabled, and on which bit positions enabled drivers disagreed. The disagreement status is for information only. It never changes the resolved value, and several drivers enabled together is treated as a legal condition.

The resolved word is combinational from the inputs. The status outputs show the inputs sampled at the previous rising clock edge, and a synchronous active-high reset clears them.

Top module: `shared_bus_resolver`

## Requirements
- R1: Bit b of `bus_value` is 0 whenever any driver d with `drv_en_n[d]`=0 presents 0 on bit b. The bits of driver d sit at `drv_data[d*BUS_W +: BUS_W]`.
- R2: A driver whose enable is 1 has no effect on `bus_value`, whatever data it presents.
- R3: When every enable is 1, `bus_value` is all ones, with no pull-up input needed.
- R4: When enabled drivers present both 1 and 0 on a bit, that bit of `bus_value` is 0.
- R5: Several enabled drivers presenting the same word produce exactly that word on `bus_value`. This is a legal condition with no error indication.
- R6: Each bit position is resolved independently, so a conflict on one bit does not disturb the other bits.
- R7: One clock after a rising edge with reset low, `enabled_vec[d]` equals the inverse of the `drv_en_n[d]` sampled at that edge.
- R8: One clock after a rising edge with reset low, `enabled_cnt` equals the number of drivers that were enabled at that edge.
- R9: One clock after a rising edge with reset low, `conflict_bits[b]` is 1 exactly when enabled drivers presented both 1 and 0 on bit b at that edge. `conflict_any` is the OR of those bits.
- R10: The conflict status is observe-only: the `bus_value` seen during a conflict matches the R1–R4 rules.
- R11: A rising edge with `rst`=1 clears `enabled_vec`, `enabled_cnt`, `conflict_bits` and `conflict_any` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the status registers |
| rst | input | 1 | Synchronous active-high reset of the status registers |
| drv_data | input | NUM_DRV*BUS_W | Data words of all drivers; driver d at bits d*BUS_W +: BUS_W |
| drv_en_n | input | NUM_DRV | Active-low enable, one per driver |
| bus_value | output | BUS_W | Resolved bus word (combinational) |
| enabled_vec | output | NUM_DRV | Registered set of drivers enabled at the last edge |
| enabled_cnt | output | $clog2(NUM_DRV+1) | Registered count of enabled drivers |
| conflict_bits | output | BUS_W | Registered per-bit disagreement flags |
| conflict_any | output | 1 | Registered OR of the disagreement flags |

## Verification
The assertions check on every cycle that an idle bus reads all ones, and that the registered enable set follows the inverted enables one cycle later. They also check that the count agrees with that set, that no bit flagged as conflicting was resolved high, and that reset clears every status output. Two behaviours can only be shown by the bench's scenarios against its behavioural model: that disabled drivers' data is ignored, and that each bit resolves independently. Those scenarios are idle, single driver, masked driver, agreeing drivers, opposing drivers and mixed per-bit patterns, plus a long random run and a reset in the middle of a run.

// File: rtl/sbus_pkg.sv
package sbus_pkg;
  typedef struct packed {
    logic resolved;
    logic saw_hi;
    logic saw_lo;
  } sbus_bit_obs_t;
endpackage

// File: rtl/sbus_bit_resolve.sv
module sbus_bit_resolve
  import sbus_pkg::*;
#(
  parameter int NUM_DRV = 4
) (
  input  logic [NUM_DRV-1:0] lane_data,
  input  logic [NUM_DRV-1:0] lane_en_n,
  output sbus_bit_obs_t      obs
);
  // A disabled driver is forced to 1 so it cannot pull the AND low.
  always_comb begin
    obs.resolved = &(lane_data | lane_en_n);
    obs.saw_hi   = |(lane_data & ~lane_en_n);
    obs.saw_lo   = |(~lane_data & ~lane_en_n);
  end
endmodule

// File: rtl/sbus_enable_count.sv
module sbus_enable_count #(
  parameter int NUM_DRV = 4,
  parameter int CNT_W   = $clog2(NUM_DRV + 1)
) (
  input  logic [NUM_DRV-1:0] en_n,
  output logic [CNT_W-1:0]   count
);
  always_comb begin
    count = '0;
    for (int d = 0; d < NUM_DRV; d++) begin
      count = count + CNT_W'(~en_n[d]);
    end
  end
endmodule

// File: rtl/sbus_status_reg.sv
module sbus_status_reg #(
  parameter int NUM_DRV = 4,
  parameter int BUS_W   = 8,
  parameter int CNT_W   = $clog2(NUM_DRV + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_DRV-1:0] en_n,
  input  logic [CNT_W-1:0]   cnt_next,
  input  logic [BUS_W-1:0]   clash_next,
  output logic [NUM_DRV-1:0] enabled_q,
  output logic [CNT_W-1:0]   cnt_q,
  output logic [BUS_W-1:0]   clash_q,
  output logic               clash_any_q
);
  always_ff @(posedge clk) begin
    if (rst) begin
      enabled_q   <= '0;
      cnt_q       <= '0;
      clash_q     <= '0;
      clash_any_q <= 1'b0;
    end else begin
      enabled_q   <= ~en_n;
      cnt_q       <= cnt_next;
      clash_q     <= clash_next;
      clash_any_q <= |clash_next;
    end
  end
endmodule

// File: rtl/shared_bus_resolver.sv
module shared_bus_resolver
  import sbus_pkg::*;
#(
  parameter int NUM_DRV = 4,
  parameter int BUS_W   = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic [NUM_DRV*BUS_W-1:0]   drv_data,
  input  logic [NUM_DRV-1:0]         drv_en_n,
  output logic [BUS_W-1:0]           bus_value,
  output logic [NUM_DRV-1:0]         enabled_vec,
  output logic [$clog2(NUM_DRV+1)-1:0] enabled_cnt,
  output logic [BUS_W-1:0]           conflict_bits,
  output logic                       conflict_any
);
  localparam int CNT_W = $clog2(NUM_DRV + 1);

  logic [BUS_W-1:0][NUM_DRV-1:0] lanes;
  sbus_bit_obs_t [BUS_W-1:0]     obs;
  logic [BUS_W-1:0]              clash_next;
  logic [CNT_W-1:0]              cnt_next;

  for (genvar b = 0; b < BUS_W; b++) begin : g_bit
    for (genvar d = 0; d < NUM_DRV; d++) begin : g_lane
      assign lanes[b][d] = drv_data[d*BUS_W + b];
    end
    sbus_bit_resolve #(.NUM_DRV(NUM_DRV)) u_res (
      .lane_data (lanes[b]),
      .lane_en_n (drv_en_n),
      .obs       (obs[b])
    );
    assign bus_value[b]  = obs[b].resolved;
    assign clash_next[b] = obs[b].saw_hi & obs[b].saw_lo;
  end

  sbus_enable_count #(.NUM_DRV(NUM_DRV), .CNT_W(CNT_W)) u_cnt (
    .en_n  (drv_en_n),
    .count (cnt_next)
  );

  sbus_status_reg #(.NUM_DRV(NUM_DRV), .BUS_W(BUS_W), .CNT_W(CNT_W)) u_stat (
    .clk         (clk),
    .rst         (rst),
    .en_n        (drv_en_n),
    .cnt_next    (cnt_next),
    .clash_next  (clash_next),
    .enabled_q   (enabled_vec),
    .cnt_q       (enabled_cnt),
    .clash_q     (conflict_bits),
    .clash_any_q (conflict_any)
  );
endmodule

// File: rtl/sbus_checker.sv
module sbus_checker #(
  parameter int NUM_DRV = 4,
  parameter int BUS_W   = 8
) (
  input logic                         clk,
  input logic                         rst,
  input logic [NUM_DRV*BUS_W-1:0]     drv_data,
  input logic [NUM_DRV-1:0]           drv_en_n,
  input logic [BUS_W-1:0]             bus_value,
  input logic [NUM_DRV-1:0]           enabled_vec,
  input logic [$clog2(NUM_DRV+1)-1:0] enabled_cnt,
  input logic [BUS_W-1:0]             conflict_bits,
  input logic                         conflict_any
);
  // R3: idle bus floats high
  a_r3_idle_high: assert property (@(posedge clk) disable iff (rst)
    (&drv_en_n) |-> (&bus_value));

  // R7: enabled set follows inverted enables one cycle later
  a_r7_enable_capture: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> (enabled_vec == ~$past(drv_en_n)));

  // R8: count agrees with the registered set
  a_r8_count_matches: assert property (@(posedge clk) disable iff (rst)
    enabled_cnt == $bits(enabled_cnt)'($countones(enabled_vec)));

  // R9: summary flag agrees with per-bit flags
  a_r9_any_matches: assert property (@(posedge clk) disable iff (rst)
    conflict_any == (conflict_bits != '0));

  // R4: a flagged bit was resolved low
  a_r4_conflict_low: assert property (@(posedge clk) disable iff (rst)
    (!rst) |=> ((conflict_bits & $past(bus_value)) == '0));

  // R11: reset clears all status
  a_r11_reset_clears: assert property (@(posedge clk)
    rst |=> (enabled_vec == '0 && enabled_cnt == '0 &&
             conflict_bits == '0 && !conflict_any));
endmodule

bind shared_bus_resolver sbus_checker #(.NUM_DRV(NUM_DRV), .BUS_W(BUS_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .drv_data      (drv_data),
  .drv_en_n      (drv_en_n),
  .bus_value     (bus_value),
  .enabled_vec   (enabled_vec),
  .enabled_cnt   (enabled_cnt),
  .conflict_bits (conflict_bits),
  .conflict_any  (conflict_any)
);

// File: tb/shared_bus_resolver_bench.sv
module shared_bus_resolver_bench;
  localparam int N = 4;
  localparam int W = 8;
  localparam int CW = $clog2(N + 1);

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [N*W-1:0]   drv_data = '0;
  logic [N-1:0]     drv_en_n = '1;
  logic [W-1:0]     bus_value;
  logic [N-1:0]     enabled_vec;
  logic [CW-1:0]    enabled_cnt;
  logic [W-1:0]     conflict_bits;
  logic             conflict_any;

  int checks = 0;
  int failures = 0;
  bit done = 0;

  // expected registered state (model)
  logic [N-1:0]  m_vec = '0;
  logic [CW-1:0] m_cnt = '0;
  logic [W-1:0]  m_clash = '0;

  always #2.5 clk = ~clk;

  shared_bus_resolver #(.NUM_DRV(N), .BUS_W(W)) u_shared_bus_resolver (
    .clk(clk), .rst(rst), .drv_data(drv_data), .drv_en_n(drv_en_n),
    .bus_value(bus_value), .enabled_vec(enabled_vec), .enabled_cnt(enabled_cnt),
    .conflict_bits(conflict_bits), .conflict_any(conflict_any)
  );

  function automatic logic [W-1:0] word_of(input logic [N*W-1:0] all, input int d);
    return all[d*W +: W];
  endfunction

  function automatic logic [W-1:0] model_bus(input logic [N*W-1:0] all, input logic [N-1:0] en_n);
    logic [W-1:0] r = '1;
    for (int d = 0; d < N; d++)
      if (!en_n[d]) r = r & word_of(all, d);
    return r;
  endfunction

  function automatic logic [W-1:0] model_clash(input logic [N*W-1:0] all, input logic [N-1:0] en_n);
    logic [W-1:0] r;
    for (int b = 0; b < W; b++) begin
      int ones = 0, zeros = 0;
      for (int d = 0; d < N; d++)
        if (!en_n[d]) begin
          if (all[d*W + b]) ones++; else zeros++;
        end
      r[b] = (ones > 0) && (zeros > 0);
    end
    return r;
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_regs(input string tv, input string tc, input string tx);
    check(tv, 32'(enabled_vec), 32'(m_vec));
    check(tc, 32'(enabled_cnt), 32'(m_cnt));
    check(tx, 32'(conflict_bits), 32'(m_clash));
    check(tx, 32'(conflict_any), 32'(m_clash != '0));
  endtask

  // drive at negedge, check bus, clock, then check registers
  task automatic step(input string tag, input logic [N*W-1:0] d, input logic [N-1:0] en_n);
    int cnt = 0;
    @(negedge clk);
    drv_data = d;
    drv_en_n = en_n;
    #1;
    check(tag, 32'(bus_value), 32'(model_bus(d, en_n)));
    for (int i = 0; i < N; i++) if (!en_n[i]) cnt++;
    @(posedge clk);
    if (rst) begin
      m_vec = '0; m_cnt = '0; m_clash = '0;
    end else begin
      m_vec = ~en_n; m_cnt = CW'(cnt); m_clash = model_clash(d, en_n);
    end
    #1;
    check_regs("R7", "R8", "R9");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin : stim
    // reset state (R11)
    repeat (3) @(posedge clk);
    #1;
    check_regs("R11", "R11", "R11");
    step("R11", {8'h12, 8'h34, 8'h00, 8'hFF}, 4'b0000);
    rst = 1'b0;

    // R3: idle bus all ones regardless of data
    step("R3", {8'h00, 8'h00, 8'h00, 8'h00}, 4'b1111);
    check("R3", 32'(bus_value), 32'hFF);
    // R1: single driver
    step("R1", {8'hFF, 8'hFF, 8'hFF, 8'hA5}, 4'b1110);
    check("R1", 32'(bus_value), 32'hA5);
    // R2: disabled driver with zeros does not pull low
    step("R2", {8'h00, 8'h00, 8'h3C, 8'h00}, 4'b1101);
    check("R2", 32'(bus_value), 32'h3C);
    // R4 / R10: opposing drivers resolve low, flags set
    step("R4", {8'h0F, 8'hAA, 8'h55, 8'hF0}, 4'b0110);
    check("R10", 32'(conflict_bits), 32'hFF);
    // R5: agreeing drivers
    step("R5", {8'h5A, 8'h5A, 8'h5A, 8'h5A}, 4'b0000);
    check("R5", 32'(conflict_any), 32'h0);
    // R6: conflict on one bit only
    step("R6", {8'h00, 8'h00, 8'hFF, 8'hFE}, 4'b1100);
    check("R6", 32'(conflict_bits), 32'h01);
    // conflict cleared on idle afterwards (R9)
    step("R9", {8'h00, 8'hFF, 8'h00, 8'hFF}, 4'b1111);

    // random run
    for (int i = 0; i < 300; i++) begin
      logic [N*W-1:0] rd = {$urandom, $urandom} ;
      logic [N-1:0]   re = N'($urandom);
      step("R1", rd, re);
    end

    // reset in the middle of a conflicting state (R11)
    step("R9", {8'hFF, 8'h00, 8'hFF, 8'h00}, 4'b0000);
    rst = 1'b1;
    step("R11", {8'hFF, 8'h00, 8'hFF, 8'h00}, 4'b0000);
    rst = 1'b0;
    step("R7", {8'h01, 8'h02, 8'h04, 8'h08}, 4'b0101);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule